// File: doc/BRIEF.md
# Serial Signature Analyzer with Golden Compare

This block compacts a serial test response into a fixed-width signature. Each accepted response bit is folded into an N-stage shift register with feedback taps set by a programmable characteristic polynomial. When the test ends, the signature is compared with a golden value supplied from outside, and a sticky error flag is raised on a mismatch.

A build-time parameter selects the wiring. In the modular form, XOR gates sit between stages. In the standard form, one parity tree feeds the first stage. In the modular form the final register holds the remainder of the response polynomial divided by the characteristic polynomial. In the standard form it holds the last N feedback values of the division recurrence.

A test proceeds in four steps. First a clear. Then the response bits are sent with a valid strobe, with the first bit as the highest power. An end-of-test pulse follows in a later cycle. The error output is then read. After end-of-test the register is frozen until the next clear.

Top module: `sig_analyzer`

## Requirements
- R1: Synchronous active-low reset, or a high `clr` on a clock edge, sets `signature` to zero and `err` to 0 after that edge. `clr` overrides `eot` and `bit_vld` in the same cycle.
- R2: In modular form, after L accepted bits sent first-bit-highest-power from the cleared state, `signature` bit i holds the coefficient of X^i of M(X) mod P(X). `poly_taps` bit i is the coefficient of X^i of P(X), and the X^N term is implied.
- R3: For modular form with N=3 and `poly_taps`=3'b101 (P = X^3+X^2+1), the stream 1,0,1,1,0,0,0,1 leaves `signature`=3'b100 (the remainder X^2).
- R4: In standard form, each accepted bit m updates the state s to {s[N-2:0], f}. Here f is m XOR the parity of (s AND the bit-reversed `poly_taps`), so s[k] is the feedback value from k+1 accepted bits ago.
- R5: A cycle with `bit_vld` low leaves `signature` unchanged.
- R6: In modular form, a stream of L <= N bits leaves exactly that stream as the signature, so any two distinct short streams give distinct signatures.
- R7: When `eot` is sampled high while not frozen and `signature` differs from `golden`, `err` is 1 from the next cycle on.
- R8: When `eot` is sampled high and `signature` equals `golden`, `err` stays 0.
- R9: Once set, `err` stays 1 until reset or `clr`.
- R10: After `eot`, further valid bits and further `eot` pulses have no effect on `signature` or `err` until reset or `clr`.
- R11: In modular form with `poly_taps` bit 0 set, a response that differs from the fault-free one in a single bit gives a different signature, and `err` is raised against the fault-free golden value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of signature, error and freeze |
| bit_in | input | 1 | Serial response bit |
| bit_vld | input | 1 | `bit_in` is accepted on this edge |
| eot | input | 1 | End of test: compare and freeze |
| poly_taps | input | N | Low coefficients of P(X), bit i for X^i |
| golden | input | N | Fault-free signature |
| signature | output | N | Current register contents |
| err | output | 1 | Sticky mismatch flag |

## Verification
The assertions guard the properties that hold on every cycle. Clear and reset force zero. Idle cycles and the frozen state hold the signature. The error flag is sticky, and it rises only right after an end-of-test whose signature differed from the golden value. Whether the register contents are the true division remainder, or the true standard-form recurrence, can only be shown by the bench's scenarios. These compare random long streams against a software long division and an independent recurrence. The bench also checks the worked three-stage example, the short-stream and single-bit-error detection cases, and the clear-over-end-of-test priority.

// File: rtl/ssa_pkg.sv
// Shared definitions for the serial signature analyzer.
// Assumes: nothing beyond standard SystemVerilog.
package ssa_pkg;
    // Wiring form of the compaction register.
    typedef enum logic {
        FORM_MODULAR  = 1'b0,
        FORM_STANDARD = 1'b1
    } form_e;
endpackage

// File: rtl/ssa_next_state.sv
// Next-state function of the signature register for one accepted bit.
// Modular form: internal XORs, state tracks the running remainder.
// Standard form: single parity feedback into the first stage.
// Assumes: N >= 2; taps bit i is the X^i coefficient, X^N implied.
module ssa_next_state #(
    parameter int            N    = 8,
    parameter ssa_pkg::form_e FORM = ssa_pkg::FORM_MODULAR
) (
    input  logic [N-1:0] state,
    input  logic [N-1:0] taps,
    input  logic         din,
    output logic [N-1:0] nxt
);
    generate
        if (FORM == ssa_pkg::FORM_MODULAR) begin : g_modular
            logic top_bit;
            // Multiply by X, add the new bit, reduce by P when X^N appears.
            assign top_bit = state[N-1];
            assign nxt     = {state[N-2:0], din} ^ (taps & {N{top_bit}});
        end else begin : g_standard
            logic [N-1:0] rev_taps;
            logic         fb;
            for (genvar k = 0; k < N; k++) begin : g_rev
                // Stage k holds the value from k+1 steps ago: weight X^(N-1-k).
                assign rev_taps[k] = taps[N-1-k];
            end
            // Parity of tapped stages plus the incoming bit.
            assign fb  = din ^ (^(state & rev_taps));
            assign nxt = {state[N-2:0], fb};
        end
    endgenerate
endmodule

// File: rtl/ssa_compare.sv
// End-of-test comparator: on the first eot after a clear, latches whether
// the signature differs from the golden value, and freezes the analyzer.
// Assumes: eot arrives in a cycle after the last response bit.
module ssa_compare #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         eot,
    input  logic [N-1:0] signature,
    input  logic [N-1:0] golden,
    output logic         err,
    output logic         frozen
);
    logic mismatch;

    // Bitwise difference reduced to a single flag.
    assign mismatch = |(signature ^ golden);

    // Latch the verdict once per test and hold it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err    <= 1'b0;
            frozen <= 1'b0;
        end else if (eot && !frozen) begin
            err    <= mismatch;
            frozen <= 1'b1;
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(eot) && $past(signature != golden)));
endmodule

// File: rtl/sig_analyzer.sv
// Serial signature analyzer: single-input compaction register with a
// programmable characteristic polynomial and built-in golden compare.
// Assumes: N >= 2; response bits sent first-bit-highest-power after clr.
module sig_analyzer #(
    parameter int             N    = 8,
    parameter ssa_pkg::form_e FORM = ssa_pkg::FORM_MODULAR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_in,
    input  logic         bit_vld,
    input  logic         eot,
    input  logic [N-1:0] poly_taps,
    input  logic [N-1:0] golden,
    output logic [N-1:0] signature,
    output logic         err
);
    logic [N-1:0] sig_q;
    logic [N-1:0] sig_nxt;
    logic         frozen;

    ssa_next_state #(.N(N), .FORM(FORM)) u_next (
        .state (sig_q),
        .taps  (poly_taps),
        .din   (bit_in),
        .nxt   (sig_nxt)
    );

    ssa_compare #(.N(N)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .eot       (eot),
        .signature (sig_q),
        .golden    (golden),
        .err       (err),
        .frozen    (frozen)
    );

    // Signature register: cleared to zero, advances only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sig_q <= '0;
        end else if (bit_vld && !frozen) begin
            sig_q <= sig_nxt;
        end
    end

    assign signature = sig_q;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (signature == '0 && !err));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !clr) |=> $stable(signature));

    assert_frozen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clr) |=> ($stable(signature) && $stable(err)));
endmodule

// File: tb/sig_analyzer_bench.sv
`timescale 1ns/1ps
module sig_analyzer_bench;
    localparam int N = 8;
    localparam logic [N-1:0] TAPS = 8'h1D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic eot = 1'b0;
    logic [N-1:0] gold_m = '0;
    logic [N-1:0] gold_t = '0;
    logic [2:0]   gold_s = '0;
    logic [N-1:0] sig_m, sig_t;
    logic [2:0]   sig_s;
    logic err_m, err_t, err_s;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sig_analyzer #(.N(N), .FORM(ssa_pkg::FORM_MODULAR)) u_sig_analyzer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(bit_in), .bit_vld(bit_vld),
        .eot(eot), .poly_taps(TAPS), .golden(gold_m), .signature(sig_m), .err(err_m));

    sig_analyzer #(.N(N), .FORM(ssa_pkg::FORM_STANDARD)) u_sig_analyzer_std (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(bit_in), .bit_vld(bit_vld),
        .eot(eot), .poly_taps(TAPS), .golden(gold_t), .signature(sig_t), .err(err_t));

    sig_analyzer #(.N(3), .FORM(ssa_pkg::FORM_MODULAR)) u_sig_analyzer_n3 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(bit_in), .bit_vld(bit_vld),
        .eot(eot), .poly_taps(3'b101), .golden(gold_s), .signature(sig_s), .err(err_s));

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Remainder by long division on the full polynomial (first bit = top power).
    function automatic logic [N-1:0] div_rem(input logic [127:0] m, input int len);
        logic [127:0] work = m;
        logic [127:0] p = {119'd0, 1'b1, TAPS};
        for (int d = len - 1; d >= N; d--)
            if (work[d]) work = work ^ (p << (d - N));
        return work[N-1:0];
    endfunction

    // Standard-form recurrence: f_t = m_t + sum_j taps[N-j] f_{t-j}.
    function automatic logic [N-1:0] std_model(input logic [127:0] m, input int len);
        logic [127:0] f = '0;
        logic [N-1:0] s = '0;
        for (int t = 0; t < len; t++) begin
            logic v = m[len-1-t];
            for (int j = 1; j <= N; j++)
                if (t - j >= 0 && TAPS[N-j]) v = v ^ f[t-j];
            f[t] = v;
        end
        for (int k = 0; k < N; k++)
            s[k] = (len - 1 - k >= 0) ? f[len-1-k] : 1'b0;
        return s;
    endfunction

    task automatic do_clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic send(input logic [127:0] m, input int len);
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = m[len-1-t];
        end
        @(negedge clk) bit_vld = 1'b0;
    endtask

    task automatic pulse_eot();
        @(negedge clk) eot = 1'b1;
        @(negedge clk) eot = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic t_reset();
        check("R1", "sig after reset", 64'(sig_m), 64'd0);
        check("R1", "err after reset", 64'(err_m), 64'd0);
        check("R1", "std sig after reset", 64'(sig_t), 64'd0);
    endtask

    task automatic t_example();
        do_clear();
        send(128'hB1, 8);
        check("R3", "worked example remainder", 64'(sig_s), 64'h4);
        gold_s = 3'b100;
        pulse_eot();
        check("R8", "example match err", 64'(err_s), 64'd0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 12; i++) begin
            int len = 9 + int'($urandom % 56);
            logic [127:0] m = rnd128();
            do_clear();
            send(m, len);
            check("R2", "modular remainder", 64'(sig_m), 64'(div_rem(m, len)));
            check("R4", "standard recurrence", 64'(sig_t), 64'(std_model(m, len)));
            gold_m = div_rem(m, len);
            gold_t = std_model(m, len);
            pulse_eot();
            check("R8", "modular match err", 64'(err_m), 64'd0);
            check("R8", "standard match err", 64'(err_t), 64'd0);
        end
    endtask

    task automatic t_idle();
        logic [N-1:0] held;
        do_clear();
        send(128'h5A3C, 16);
        held = sig_m;
        repeat (6) @(negedge clk) bit_in = ~bit_in;
        check("R5", "idle hold", 64'(sig_m), 64'(held));
    endtask

    task automatic t_short();
        for (int len = 1; len <= N; len++) begin
            logic [127:0] m = rnd128() & ((128'd1 << len) - 1);
            do_clear();
            send(m, len);
            check("R6", "short stream kept", 64'(sig_m), 64'(m[N-1:0]));
        end
    endtask

    task automatic t_mismatch();
        logic [127:0] m = rnd128();
        logic [N-1:0] frz;
        do_clear();
        send(m, 40);
        gold_m = div_rem(m, 40) ^ 8'h01;
        pulse_eot();
        check("R7", "mismatch raises err", 64'(err_m), 64'd1);
        frz = sig_m;
        send(rnd128(), 20);
        check("R10", "frozen signature", 64'(sig_m), 64'(frz));
        gold_m = frz;
        pulse_eot();
        check("R10", "second eot ignored", 64'(err_m), 64'd1);
        repeat (3) @(negedge clk);
        check("R9", "err sticky", 64'(err_m), 64'd1);
        do_clear();
        check("R1", "clear zero sig", 64'(sig_m), 64'd0);
        check("R1", "clear zero err", 64'(err_m), 64'd0);
    endtask

    task automatic t_flip();
        for (int i = 0; i < 4; i++) begin
            logic [127:0] m = rnd128();
            int pos = int'($urandom % 48);
            logic [127:0] bad = m ^ (128'd1 << pos);
            do_clear();
            gold_m = div_rem(m, 48);
            send(bad, 48);
            check("R11", "single-bit error changes sig",
                  64'(sig_m != gold_m), 64'd1);
            pulse_eot();
            check("R11", "single-bit error flagged", 64'(err_m), 64'd1);
        end
    endtask

    task automatic t_clear_priority();
        do_clear();
        send(128'h3F, 8);
        gold_m = ~sig_m;
        @(negedge clk) begin clr = 1'b1; eot = 1'b1; end
        @(negedge clk) begin clr = 1'b0; eot = 1'b0; end
        check("R1", "clr beats eot err", 64'(err_m), 64'd0);
        check("R1", "clr beats eot sig", 64'(sig_m), 64'd0);
        send(128'h1, 1);
        check("R1", "not frozen after clr", 64'(sig_m), 64'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_random();
        t_idle();
        t_short();
        t_mismatch();
        t_flip();
        t_clear_priority();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule